// File: doc/BRIEF.md
# Memory Bit Invert Unit

This block performs one atomic read-modify-write on a single byte of memory: it reads the byte, flips one chosen bit, and writes the byte back to the same address. It also reports the bit's original state on a zero flag, which is set when that bit was clear and cleared when it was set. The decode stage hands the block the operand fields and register values it has already extracted. One start pulse begins the operation.

There are two addressing forms. In the displacement form, the address is a base register value plus a signed 16-bit displacement, and the bit number comes from a 3-bit immediate. In the register form, the address is the base register value with no offset, and the bit number comes from the low three bits of a second register. The read and the write go out back to back on a byte-wide request/acknowledge memory port. A lock output stays high across both accesses, so no other master can change the byte between them.

Top module: `bit_invert_unit`

## Requirements
- R1: When `useRegForm` is 0, the access address equals `baseVal` plus `disp` sign-extended to 32 bits, modulo 2^32. The bit number is `immBit`, and `bitRegVal` has no effect.
- R2: When `useRegForm` is 1, the access address equals `baseVal`. The bit number is `bitRegVal[2:0]`. `disp`, `immBit` and `bitRegVal[31:3]` have no effect.
- R3: Each operation makes exactly one read (`memReq`=1, `memWe`=0), followed by exactly one write (`memReq`=1, `memWe`=1) to the same address. Nothing comes between them.
- R4: After the operation, `zFlag` equals the inverse of the selected bit as it was read. It keeps that value until the next operation's read completes.
- R5: The written byte equals the read byte with only the selected bit inverted. Bit n is weighted 2^n, with bit 0 the least significant.
- R6: `memLock` is 1 in every cycle in which `memReq` is 1, and it is 0 whenever `busy` is 0.
- R7: With zero wait states, `done` is high for exactly one cycle. It is first visible three cycle boundaries after the start is driven, so one operation takes three clocks.
- R8: While `memAck` is low, `memReq`, `memWe`, `memAddr` and `memWdata` hold their values.
- R9: A `start` that arrives while `busy` is 1 is ignored. It adds no access and does not change the address, the data or the flag.
- R10: After reset, `memReq`, `memLock`, `busy`, `done` and `zFlag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (accepted only when idle) |
| useRegForm | input | 1 | 0: displacement form, 1: register form |
| baseVal | input | 32 | Base register value |
| disp | input | 16 | Signed displacement |
| immBit | input | 3 | Immediate bit number |
| bitRegVal | input | 32 | Bit-number register value |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 for write, 0 for read |
| memLock | output | 1 | Bus lock across the read and the write |
| memAddr | output | 32 | Byte address |
| memWdata | output | 8 | Write data |
| memRdata | input | 8 | Read data, valid when acknowledged |
| memAck | input | 1 | Access completes in this cycle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| zFlag | output | 1 | Inverse of the original bit |

## Verification
The hardest case to reach from the ports is a second start arriving while the first operation is still between its read and its write. If it were wrongly accepted, it would re-latch the address and bit number in the middle of the operation. The stimulus raises start again, with the other form and a different bit, in the cycle right after acceptance. The bench then checks that exactly one read and one write happened and that both match the first request. The rest of the bench sweeps every bit number in both forms, across several byte patterns and at zero and two wait states. Each form is fed garbage in the operands it must ignore.

// File: rtl/bit_invert_pkg.sv
package bit_invert_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_DONE  = 2'd3
  } bitInvState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic captureOp;    // latch address and bit number
    logic captureRead;  // latch read byte and update flag
    logic writing;      // write access on the port
  } bitInvCtl_t;

endpackage

// File: rtl/bit_invert_ctrl.sv
module bit_invert_ctrl
  import bit_invert_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       memAck,
  output logic       memReq,
  output logic       memWe,
  output logic       memLock,
  output logic       busy,
  output logic       done,
  output bitInvCtl_t ctl
);

  bitInvState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:  if (start)  nextState = ST_READ;
      ST_READ:  if (memAck) nextState = ST_WRITE;
      ST_WRITE: if (memAck) nextState = ST_DONE;
      ST_DONE:              nextState = ST_IDLE;
      default:              nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    memReq          = (state == ST_READ) || (state == ST_WRITE);
    memWe           = (state == ST_WRITE);
    memLock         = memReq;
    busy            = (state != ST_IDLE);
    done            = (state == ST_DONE);
    ctl.captureOp   = (state == ST_IDLE) && start;
    ctl.captureRead = (state == ST_READ) && memAck;
    ctl.writing     = (state == ST_WRITE);
  end

  // R3: a write begins only right after an acknowledged read
  a_r3_write_after_read: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWe) |-> $past(memReq && !memWe && memAck));

  // R6: lock covers every request
  a_r6_lock_on_req: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> memLock);

  // R8: an unacknowledged request keeps its kind
  a_r8_hold_req: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memWe)));

  // R7: completion is a single-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: no new operation starts while busy
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

endmodule

// File: rtl/bit_invert_datapath.sv
module bit_invert_datapath
  import bit_invert_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16,
  parameter int DATA_W = 8,
  parameter int REG_W  = 32,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  bitInvCtl_t        ctl,
  input  logic              useRegForm,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [DISP_W-1:0] disp,
  input  logic [BIT_W-1:0]  immBit,
  input  logic [REG_W-1:0]  bitRegVal,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              zFlag
);

  logic [ADDR_W-1:0] dispExt;
  logic [ADDR_W-1:0] addrNext;
  logic [BIT_W-1:0]  bitNext;
  logic [ADDR_W-1:0] opAddr;
  logic [BIT_W-1:0]  opBit;
  logic [DATA_W-1:0] rdByte;
  logic [DATA_W-1:0] flipMask;

  generate
    if (DISP_W < ADDR_W) begin : g_sext
      assign dispExt = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
    end else begin : g_trunc
      assign dispExt = disp[ADDR_W-1:0];
    end
  endgenerate

  always_comb begin
    addrNext = useRegForm ? baseVal : (baseVal + dispExt);
    bitNext  = useRegForm ? bitRegVal[BIT_W-1:0] : immBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opAddr <= '0;
      opBit  <= '0;
    end else if (ctl.captureOp) begin
      opAddr <= addrNext;
      opBit  <= bitNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdByte <= '0;
      zFlag  <= 1'b0;
    end else if (ctl.captureRead) begin
      rdByte <= memRdata;
      zFlag  <= ~memRdata[opBit];
    end
  end

  always_comb begin
    flipMask = '0;
    flipMask[opBit] = 1'b1;
    memWdata = rdByte ^ flipMask;
    memAddr  = opAddr;
  end

  // R4: flag is the inverse of the bit just read
  a_r4_flag_inverse: assert property (@(posedge clk) disable iff (!rstN)
    ctl.captureRead |=> (zFlag == !$past(memRdata[opBit])));

  // R5: written bit agrees with the flag (both are the inverted original)
  a_r5_written_bit: assert property (@(posedge clk) disable iff (!rstN)
    ctl.writing |-> (memWdata[opBit] == zFlag));

  // R4: flag changes only when a read completes
  a_r4_flag_held: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.captureRead |=> $stable(zFlag));

endmodule

// File: rtl/bit_invert_unit.sv
module bit_invert_unit
  import bit_invert_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16,
  parameter int DATA_W = 8,
  parameter int REG_W  = 32,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              useRegForm,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [DISP_W-1:0] disp,
  input  logic [BIT_W-1:0]  immBit,
  input  logic [REG_W-1:0]  bitRegVal,
  output logic              memReq,
  output logic              memWe,
  output logic              memLock,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memAck,
  output logic              busy,
  output logic              done,
  output logic              zFlag
);

  bitInvCtl_t ctl;

  bit_invert_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .memAck  (memAck),
    .memReq  (memReq),
    .memWe   (memWe),
    .memLock (memLock),
    .busy    (busy),
    .done    (done),
    .ctl     (ctl)
  );

  bit_invert_datapath #(
    .ADDR_W (ADDR_W),
    .DISP_W (DISP_W),
    .DATA_W (DATA_W),
    .REG_W  (REG_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .useRegForm (useRegForm),
    .baseVal    (baseVal),
    .disp       (disp),
    .immBit     (immBit),
    .bitRegVal  (bitRegVal),
    .memRdata   (memRdata),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .zFlag      (zFlag)
  );

  // R3: the write targets the address that was read
  a_r3_same_addr: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |-> (memAddr == $past(memAddr)));

  // R8: address and data held while waiting
  a_r8_hold_payload: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> ($stable(memAddr) && $stable(memWdata)));

  // R6: no lock while idle
  a_r6_idle_unlocked: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memLock);

endmodule

// File: tb/bit_invert_unit_tb.sv
module bit_invert_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rstN;
  logic        start;
  logic        useRegForm;
  logic [31:0] baseVal;
  logic [15:0] disp;
  logic [2:0]  immBit;
  logic [31:0] bitRegVal;
  logic        memReq, memWe, memLock, memAck;
  logic [31:0] memAddr;
  logic [7:0]  memWdata, memRdata;
  logic        busy, done, zFlag;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  logic [7:0] presetByte;
  int         waitSet;
  int         waitCnt;
  int         rdCnt, wrCnt, lockErr;
  logic [31:0] rdAddr, wrAddr;
  logic [7:0]  wrData;
  logic        orderOk;

  always #(CLK_PERIOD/2) clk = ~clk;

  bit_invert_unit u_dut (
    .clk(clk), .rstN(rstN), .start(start), .useRegForm(useRegForm),
    .baseVal(baseVal), .disp(disp), .immBit(immBit), .bitRegVal(bitRegVal),
    .memReq(memReq), .memWe(memWe), .memLock(memLock), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .memAck(memAck),
    .busy(busy), .done(done), .zFlag(zFlag)
  );

  // memory model: one byte of interest, configurable wait states
  assign memRdata = presetByte;
  assign memAck   = memReq && (waitCnt == waitSet);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rstN || !memReq || memAck) waitCnt <= 0;
    else                            waitCnt <= waitCnt + 1;
    if (rstN && memReq && memAck) begin
      if (!memWe) begin
        rdCnt  <= rdCnt + 1;
        rdAddr <= memAddr;
      end else begin
        wrCnt   <= wrCnt + 1;
        wrAddr  <= memAddr;
        wrData  <= memWdata;
        orderOk <= (rdCnt == wrCnt + 1);
      end
    end
    if (rstN && ((memReq && !memLock) || (!busy && memLock))) lockErr <= lockErr + 1;
  end

  initial begin
    rdCnt = 0; wrCnt = 0; lockErr = 0; waitCnt = 0;
    rdAddr = '0; wrAddr = '0; wrData = '0; orderOk = 1'b0;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic runOp(input bit form, input int bitN, input logic [7:0] pat,
                       input int waits, input bit disturb);
    logic [31:0] expAddr;
    logic [7:0]  expData;
    int r0, w0, l0, edges;
    bit timedOut;
    @(negedge clk);
    useRegForm = form;
    baseVal    = 32'h2000_0040 + 32'(bitN * 8'h11) + {24'h0, pat};
    if (bitN[0]) disp = 16'hFF00 - 16'(bitN);
    else         disp = 16'h0123 + 16'(bitN);
    if (form) begin
      immBit    = ~3'(bitN);
      bitRegVal = 32'hABCD_EF58 | 32'(bitN);
      bitRegVal[2:0] = 3'(bitN);
      expAddr   = baseVal;
    end else begin
      immBit    = 3'(bitN);
      bitRegVal = 32'h1234_5670 | 32'(3'(bitN) ^ 3'h5);
      expAddr   = baseVal + {{16{disp[15]}}, disp};
    end
    presetByte = pat;
    waitSet    = waits;
    expData    = pat ^ (8'h01 << bitN);
    r0 = rdCnt; w0 = wrCnt; l0 = lockErr;
    start = 1'b1;
    @(negedge clk);
    edges = 1;
    if (disturb) begin
      // R9: second start with other operands while busy
      useRegForm = ~form;
      immBit     = ~immBit;
      bitRegVal  = ~bitRegVal;
      baseVal    = baseVal ^ 32'h0000_0F00;
      disp       = ~disp;
    end else begin
      start = 1'b0;
    end
    timedOut = 1'b0;
    while (!done && !timedOut) begin
      @(negedge clk);
      start = 1'b0;
      edges++;
      if (edges > 1000) timedOut = 1'b1;
    end
    check(!timedOut, "R7 completion", 32'(done), 32'd1);
    if (waits == 0)
      check(edges == 3, "R7 three-cycle latency", 32'(edges), 32'd3);
    check(rdCnt - r0 == 1 && wrCnt - w0 == 1, "R3/R9 one read one write",
          32'((rdCnt - r0) * 16 + (wrCnt - w0)), 32'h11);
    check(orderOk, "R3 read before write", 32'(orderOk), 32'd1);
    check(rdAddr == expAddr, form ? "R2 read address" : "R1 read address",
          rdAddr, expAddr);
    check(wrAddr == expAddr, "R3 write address", wrAddr, expAddr);
    check(wrData == expData, "R5 write data", 32'(wrData), 32'(expData));
    check(zFlag == ~pat[bitN], "R4 zero flag", 32'(zFlag), 32'(~pat[bitN]));
    check(lockErr == l0, "R6 lock", 32'(lockErr - l0), 32'd0);
    @(negedge clk);
    check(!done && !busy, "R7 single done pulse", 32'(done), 32'd0);
    // R4: flag persists after completion
    check(zFlag == ~pat[bitN], "R4 flag held", 32'(zFlag), 32'(~pat[bitN]));
  endtask

  initial begin
    rstN = 1'b0; start = 1'b0; useRegForm = 1'b0; baseVal = '0;
    disp = '0; immBit = '0; bitRegVal = '0; presetByte = '0; waitSet = 0;
    repeat (3) @(negedge clk);
    check(!memReq && !memLock && !busy && !done && !zFlag, "R10 reset state",
          {27'd0, memReq, memLock, busy, done, zFlag}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(!memReq && !busy, "R10 idle after reset", 32'(memReq), 32'd0);

    for (int f = 0; f < 2; f++)
      for (int b = 0; b < 8; b++)
        for (int p = 0; p < 4; p++)
          for (int w = 0; w < 3; w += 2) begin
            logic [7:0] pat;
            case (p)
              0: pat = 8'h00;
              1: pat = 8'hFF;
              2: pat = 8'hA5;
              default: pat = 8'h3C;
            endcase
            runOp(f[0], b, pat, w, 1'b0);
          end

    // R9: restart attempts during operation
    runOp(1'b0, 5, 8'h5A, 0, 1'b1);
    runOp(1'b1, 2, 8'hC3, 0, 1'b1);
    runOp(1'b0, 7, 8'h81, 3, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cycles >= WATCHDOG);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=<%0d", cycles, WATCHDOG);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule